// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block sits in a host bridge and turns two I/O ports into configuration-space accesses. Software first writes a 32-bit target word to the address port at I/O 0xCF8. The word names a bus, a device, a function and a dword register number, and carries a global enable in bit 31. Software then reads or writes the data port at I/O 0xCFC. The bridge turns that access into a single request on an internal configuration interface. It then waits for a device to claim the request. If no device claims it within a fixed number of cycles, the access is aborted: a read returns all ones and a write is lost.

The host side is a valid/ready request channel paired with a valid/ready response channel, and only one access is in flight at a time. `io_req_ready` is high only while the bridge is idle. A request is taken on a clock edge where `io_req_valid` and `io_req_ready` are both high. Every accepted request produces exactly one response. The response is held, with unchanged data, until `io_rsp_ready` is sampled high. Write responses carry zero data. The configuration side has no back-pressure: `cfg_req_valid` pulses for one cycle and a claiming device answers with a one-cycle `cfg_ack`.

Top module: `cfg_port_bridge`

## Requirements
- R1: The address port decodes I/O byte addresses 0xCF8 to 0xCFB (I/O address bits 15:2 equal to 0x33E). A write there stores the write data with bits 1:0 forced to 0. A read returns the stored word. The stored word is 0 after reset.
- R2: A data-port access (byte addresses 0xCFC to 0xCFF) made while address-word bit 31 is 1 issues one configuration request. The request carries bus = bits 23:16, device = bits 15:11, function = bits 10:8, register = bits 7:2, together with the access direction and the write data.
- R3: While address-word bit 31 is 0, a data-port access issues no configuration request. A read returns 0xFFFFFFFF and a write is dropped.
- R4: A claimed read returns the data supplied with `cfg_ack`. A claimed write completes after the claim.
- R5: The bridge accepts a claim that arrives up to TIMEOUT cycles after the request cycle. If no claim arrives in that window, the access is aborted: a read returns 0xFFFFFFFF and a write is dropped. The response never comes later than this window allows.
- R6: An access to any I/O address outside both ports issues no configuration request and leaves the address word unchanged. A read of such an address returns 0xFFFFFFFF.
- R7: `io_req_ready` is low from acceptance until the response handshake, so only one access is in flight at a time. After reset it is high and no response is pending.
- R8: While `io_rsp_valid` is high and `io_rsp_ready` is low, the response stays valid with stable data.
- R9: `cfg_req_valid` lasts exactly one cycle per issued request. A `cfg_ack` arriving while no request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req_valid | input | 1 | I/O access request valid |
| io_req_ready | output | 1 | Bridge idle and able to take a request |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_addr | input | IO_AW | I/O byte address |
| io_req_wdata | input | 32 | Write data |
| io_rsp_valid | output | 1 | Response valid |
| io_rsp_ready | input | 1 | Host takes the response |
| io_rsp_rdata | output | 32 | Read data (zero for writes) |
| cfg_req_valid | output | 1 | One-cycle configuration request strobe |
| cfg_req_write | output | 1 | Configuration request direction |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_dev | output | 5 | Target device number |
| cfg_req_func | output | 3 | Target function number |
| cfg_req_reg | output | 6 | Target dword register number |
| cfg_req_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | A device claims the outstanding request |
| cfg_rdata | input | 32 | Read data returned with the claim |

## Verification
The bench drives several kinds of address word, and each tells a different fault apart. Words with the enable bit clear are distinguished from words with it set. Targets that are claimed are distinguished from targets nobody claims. Field values at the extremes (bus 0xFF, device 31, function 7, register 63) catch a misplaced or truncated field, which would send data to a different storage slot or show up in the recorded request. Claim latencies of zero, three and exactly TIMEOUT cycles separate a correct window from one that is off by a cycle. Accesses to stray I/O addresses, stalled responses and an unsolicited claim pulse show that decode, response hold and claim filtering stay independent of the data path.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] ALL_ONES = '1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } seq_state_t;

  typedef enum logic [1:0] {
    PORT_NONE,
    PORT_ADDR,
    PORT_DATA
  } port_sel_t;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] regno;
  } cfg_target_t;

  // field positions of the indirect address word
  function automatic cfg_target_t split_addr(input logic [DW-1:0] w);
    cfg_target_t t;
    t.bus   = w[23:16];
    t.dev   = w[15:11];
    t.func  = w[10:8];
    t.regno = w[7:2];
    return t;
  endfunction

endpackage

// File: rtl/cfgp_addr_latch.sv
module cfgp_addr_latch
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] addr_word,
  output logic          enable,
  output cfg_target_t   target
);

  logic [DW-1:0] addr_q;
  logic          unused_wdata_lsb;

  assign unused_wdata_lsb = ^wdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (we) begin
      addr_q <= {wdata[DW-1:2], 2'b00};
    end
  end

  assign addr_word = addr_q;
  assign enable    = addr_q[DW-1];
  assign target    = split_addr(addr_q);

endmodule

// File: rtl/cfgp_timeout.sv
module cfgp_timeout #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (run && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq
  import cfgp_pkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = IO_AW'(16'hCF8),
  parameter logic [IO_AW-1:0] DATA_PORT = IO_AW'(16'hCFC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req_valid,
  output logic             io_req_ready,
  input  logic             io_req_write,
  input  logic [IO_AW-1:0] io_req_addr,
  input  logic [DW-1:0]    io_req_wdata,
  output logic             io_rsp_valid,
  input  logic             io_rsp_ready,
  output logic [DW-1:0]    io_rsp_rdata,
  input  logic [DW-1:0]    addr_word,
  input  logic             cfg_enable,
  output logic             latch_we,
  output logic             cfg_req_valid,
  output logic             cfg_req_write,
  output logic [DW-1:0]    cfg_req_wdata,
  input  logic             cfg_ack,
  input  logic [DW-1:0]    cfg_rdata,
  output logic             timer_start,
  output logic             timer_run,
  input  logic             timer_expired
);

  seq_state_t    state_q;
  port_sel_t     port_sel;
  logic          op_write_q;
  logic [DW-1:0] op_wdata_q;
  logic [DW-1:0] rsp_q;
  logic          unused_addr_lsb;

  assign unused_addr_lsb = ^io_req_addr[1:0];

  always_comb begin
    if (io_req_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]) begin
      port_sel = PORT_ADDR;
    end else if (io_req_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]) begin
      port_sel = PORT_DATA;
    end else begin
      port_sel = PORT_NONE;
    end
  end

  assign io_req_ready  = (state_q == ST_IDLE);
  assign io_rsp_valid  = (state_q == ST_RESP);
  assign io_rsp_rdata  = rsp_q;
  assign latch_we      = io_req_ready && io_req_valid && io_req_write &&
                         (port_sel == PORT_ADDR);
  assign cfg_req_valid = (state_q == ST_ISSUE);
  assign cfg_req_write = op_write_q;
  assign cfg_req_wdata = op_wdata_q;
  assign timer_start   = (state_q == ST_ISSUE);
  assign timer_run     = (state_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_write_q <= 1'b0;
      op_wdata_q <= '0;
      rsp_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (io_req_valid) begin
            op_write_q <= io_req_write;
            op_wdata_q <= io_req_wdata;
            case (port_sel)
              PORT_ADDR: begin
                rsp_q   <= io_req_write ? '0 : addr_word;
                state_q <= ST_RESP;
              end
              PORT_DATA: begin
                if (cfg_enable) begin
                  state_q <= ST_ISSUE;
                end else begin
                  rsp_q   <= io_req_write ? '0 : ALL_ONES;
                  state_q <= ST_RESP;
                end
              end
              default: begin
                rsp_q   <= io_req_write ? '0 : ALL_ONES;
                state_q <= ST_RESP;
              end
            endcase
          end
        end
        ST_ISSUE, ST_WAIT: begin
          if (cfg_ack) begin
            rsp_q   <= op_write_q ? '0 : cfg_rdata;
            state_q <= ST_RESP;
          end else if (timer_expired) begin
            rsp_q   <= op_write_q ? '0 : ALL_ONES;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_RESP: begin
          if (io_rsp_ready) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgp_pkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter int unsigned TIMEOUT = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = IO_AW'(16'hCF8),
  parameter logic [IO_AW-1:0] DATA_PORT = IO_AW'(16'hCFC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req_valid,
  output logic             io_req_ready,
  input  logic             io_req_write,
  input  logic [IO_AW-1:0] io_req_addr,
  input  logic [31:0]      io_req_wdata,
  output logic             io_rsp_valid,
  input  logic             io_rsp_ready,
  output logic [31:0]      io_rsp_rdata,
  output logic             cfg_req_valid,
  output logic             cfg_req_write,
  output logic [7:0]       cfg_req_bus,
  output logic [4:0]       cfg_req_dev,
  output logic [2:0]       cfg_req_func,
  output logic [5:0]       cfg_req_reg,
  output logic [31:0]      cfg_req_wdata,
  input  logic             cfg_ack,
  input  logic [31:0]      cfg_rdata
);

  logic [DW-1:0] addr_word;
  logic          cfg_enable;
  cfg_target_t   target;
  logic          latch_we;
  logic          timer_start;
  logic          timer_run;
  logic          timer_expired;

  cfgp_addr_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (latch_we),
    .wdata     (io_req_wdata),
    .addr_word (addr_word),
    .enable    (cfg_enable),
    .target    (target)
  );

  cfgp_timeout #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (timer_start),
    .run     (timer_run),
    .expired (timer_expired)
  );

  cfgp_seq #(
    .IO_AW     (IO_AW),
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_req_valid  (io_req_valid),
    .io_req_ready  (io_req_ready),
    .io_req_write  (io_req_write),
    .io_req_addr   (io_req_addr),
    .io_req_wdata  (io_req_wdata),
    .io_rsp_valid  (io_rsp_valid),
    .io_rsp_ready  (io_rsp_ready),
    .io_rsp_rdata  (io_rsp_rdata),
    .addr_word     (addr_word),
    .cfg_enable    (cfg_enable),
    .latch_we      (latch_we),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_write (cfg_req_write),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_ack       (cfg_ack),
    .cfg_rdata     (cfg_rdata),
    .timer_start   (timer_start),
    .timer_run     (timer_run),
    .timer_expired (timer_expired)
  );

  assign cfg_req_bus  = target.bus;
  assign cfg_req_dev  = target.dev;
  assign cfg_req_func = target.func;
  assign cfg_req_reg  = target.regno;

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int unsigned IO_AW = 16,
  parameter int unsigned TIMEOUT = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = IO_AW'(16'hCF8)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_req_valid,
  input logic             io_req_ready,
  input logic             io_req_write,
  input logic [IO_AW-1:0] io_req_addr,
  input logic [31:0]      io_req_wdata,
  input logic             io_rsp_valid,
  input logic             io_rsp_ready,
  input logic [31:0]      io_rsp_rdata,
  input logic             cfg_req_valid,
  input logic [31:0]      addr_word
);

  logic        pending_q;
  int unsigned wait_cnt_q;

  // cycles from a configuration request until its response appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      wait_cnt_q <= 0;
    end else if (cfg_req_valid) begin
      pending_q  <= 1'b1;
      wait_cnt_q <= 0;
    end else if (io_rsp_valid) begin
      pending_q  <= 1'b0;
    end else if (pending_q) begin
      wait_cnt_q <= wait_cnt_q + 1;
    end
  end

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_valid && io_req_ready && io_req_write &&
     io_req_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2])
    |=> addr_word == {$past(io_req_wdata[31:2]), 2'b00}); // R1

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> addr_word[31]); // R3

  AST_ABORT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt_q <= TIMEOUT); // R5

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rsp_valid || cfg_req_valid) |-> !io_req_ready); // R7

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rsp_valid && !io_rsp_ready) |=> (io_rsp_valid && $stable(io_rsp_rdata))); // R8

  AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |=> !cfg_req_valid); // R9

endmodule

bind cfg_port_bridge cfgp_checker #(
  .IO_AW     (IO_AW),
  .TIMEOUT   (TIMEOUT),
  .ADDR_PORT (ADDR_PORT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .io_req_valid  (io_req_valid),
  .io_req_ready  (io_req_ready),
  .io_req_write  (io_req_write),
  .io_req_addr   (io_req_addr),
  .io_req_wdata  (io_req_wdata),
  .io_rsp_valid  (io_rsp_valid),
  .io_rsp_ready  (io_rsp_ready),
  .io_rsp_rdata  (io_rsp_rdata),
  .cfg_req_valid (cfg_req_valid),
  .addr_word     (addr_word)
);

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int IO_AW = 16;
  localparam int TIMEOUT = 16;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             io_req_valid = 1'b0;
  logic             io_req_ready;
  logic             io_req_write = 1'b0;
  logic [IO_AW-1:0] io_req_addr = '0;
  logic [31:0]      io_req_wdata = '0;
  logic             io_rsp_valid;
  logic             io_rsp_ready = 1'b0;
  logic [31:0]      io_rsp_rdata;
  logic             cfg_req_valid;
  logic             cfg_req_write;
  logic [7:0]       cfg_req_bus;
  logic [4:0]       cfg_req_dev;
  logic [2:0]       cfg_req_func;
  logic [5:0]       cfg_req_reg;
  logic [31:0]      cfg_req_wdata;
  logic             cfg_ack = 1'b0;
  logic [31:0]      cfg_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_bridge #(.IO_AW(IO_AW), .TIMEOUT(TIMEOUT)) uut (
    .clk(clk), .rst_n(rst_n),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_write(io_req_write), .io_req_addr(io_req_addr),
    .io_req_wdata(io_req_wdata),
    .io_rsp_valid(io_rsp_valid), .io_rsp_ready(io_rsp_ready),
    .io_rsp_rdata(io_rsp_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
    .cfg_req_bus(cfg_req_bus), .cfg_req_dev(cfg_req_dev),
    .cfg_req_func(cfg_req_func), .cfg_req_reg(cfg_req_reg),
    .cfg_req_wdata(cfg_req_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- device model (responder) ----------------
  function automatic bit claims(input logic [21:0] key);
    logic [7:0] b; logic [4:0] d; logic [2:0] f;
    b = key[21:14]; d = key[13:9]; f = key[8:6];
    return (b == 8'h00 && (d == 5'd3 || d == 5'd31) && f <= 3'd1) ||
           (b == 8'hFF && d == 5'd31 && f == 3'd7);
  endfunction

  function automatic logic [31:0] dflt(input logic [21:0] key);
    return {10'h1A5, key};
  endfunction

  logic [31:0] dev_mem [int];
  int          txn_count = 0;
  logic [21:0] last_key = '0;
  logic        last_write = 1'b0;
  int          resp_lat = 0;
  int          ack_cd = -1;
  logic [31:0] pend_data = '0;
  bit          stray_req = 1'b0;

  always @(negedge clk) begin
    logic [21:0] key;
    cfg_ack = 1'b0;
    if (ack_cd > 0) begin
      ack_cd--;
      if (ack_cd == 0) begin
        cfg_ack = 1'b1;
        cfg_rdata = pend_data;
        ack_cd = -1;
      end
    end
    if (stray_req) begin
      cfg_ack = 1'b1;
      cfg_rdata = 32'hDEAD_BEEF;
      stray_req = 1'b0;
    end
    if (cfg_req_valid) begin
      txn_count++;
      key = {cfg_req_bus, cfg_req_dev, cfg_req_func, cfg_req_reg};
      last_key = key;
      last_write = cfg_req_write;
      if (claims(key)) begin
        if (cfg_req_write) dev_mem[int'(key)] = cfg_req_wdata;
        pend_data = dev_mem.exists(int'(key)) ? dev_mem[int'(key)] : dflt(key);
        if (resp_lat == 0) begin
          cfg_ack = 1'b1;
          cfg_rdata = pend_data;
        end else begin
          ack_cd = resp_lat;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [32:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] exp_mem [int];
  logic [31:0] addr_model = '0;
  bit          stall_mode = 1'b0;
  bit          seen = 1'b0;
  bit          stalled = 1'b0;
  int          stall_left = 0;
  logic [31:0] held = '0;

  always @(negedge clk) begin
    logic [32:0] e;
    string t;
    if (io_rsp_valid && !io_rsp_ready) begin
      if (!seen) begin
        seen = 1'b1;
        held = io_rsp_rdata;
        stalled = 1'b0;
        stall_left = stall_mode ? 3 : 0;
        check(!io_req_ready, "R7 ready low with response pending",
              {31'b0, io_req_ready}, 32'h0);
      end
      if (stall_left > 0) begin
        stall_left--;
        stalled = 1'b1;
      end else begin
        if (stalled)
          check(io_rsp_rdata === held, "R8 data held under stall", io_rsp_rdata, held);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected response", io_rsp_rdata, 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e[32]) check(io_rsp_rdata === e[31:0], t, io_rsp_rdata, e[31:0]);
        end
        io_rsp_ready = 1'b1;
      end
    end else begin
      io_rsp_ready = 1'b0;
      seen = 1'b0;
    end
  end

  // driver: called at a falling edge, returns at a falling edge after acceptance
  task automatic io_access(input bit wr, input logic [15:0] a, input logic [31:0] d,
                           input logic [31:0] exp, input bit chk, input string tag);
    exp_q.push_back({chk, exp});
    tag_q.push_back(tag);
    io_req_valid = 1'b1;
    io_req_write = wr;
    io_req_addr  = a;
    io_req_wdata = d;
    while (!io_req_ready) @(negedge clk);
    @(negedge clk);
    io_req_valid = 1'b0;
  endtask

  function automatic logic [21:0] model_key();
    return addr_model[23:2];
  endfunction

  task automatic set_addr(input logic [31:0] w);
    addr_model = {w[31:2], 2'b00};
    io_access(1'b1, 16'hCF8, w, 32'h0, 1'b0, "R1 address write");
  endtask

  task automatic cfg_read(input string tag);
    logic [31:0] e;
    logic [21:0] k;
    k = model_key();
    if (!addr_model[31] || !claims(k)) e = ONES;
    else e = exp_mem.exists(int'(k)) ? exp_mem[int'(k)] : dflt(k);
    io_access(1'b0, 16'hCFC, 32'h0, e, 1'b1, tag);
  endtask

  task automatic cfg_write(input logic [31:0] d, input string tag);
    logic [21:0] k;
    k = model_key();
    if (addr_model[31] && claims(k)) exp_mem[int'(k)] = d;
    io_access(1'b1, 16'hCFE, d, 32'h0, 1'b0, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int t0;
    int c0;
    repeat (4) @(negedge clk);
    check(io_rsp_valid === 1'b0 && cfg_req_valid === 1'b0 && io_req_ready === 1'b1,
          "R7 reset state", {29'b0, io_rsp_valid, cfg_req_valid, io_req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset value, low bits forced, byte alias
    io_access(1'b0, 16'hCF8, 32'h0, 32'h0, 1'b1, "R1 reset value");
    set_addr(32'h8000_1A07);
    io_access(1'b0, 16'hCF8, 32'h0, 32'h8000_1A04, 1'b1, "R1 readback low bits zero");
    io_access(1'b0, 16'hCFB, 32'h0, 32'h8000_1A04, 1'b1, "R1 byte alias");
    drain();

    // R3: enable clear
    set_addr(32'h0000_1810);
    drain();
    t0 = txn_count;
    cfg_write(32'h1234_5678, "R3 write disabled");
    cfg_read("R3 read disabled returns ones");
    drain();
    check(txn_count == t0, "R3 no request while disabled", txn_count, t0);
    set_addr(32'h8000_1810);
    cfg_read("R3 dropped write left default");
    drain();

    // R2/R4: claimed, zero latency
    resp_lat = 0;
    cfg_write(32'hCAFE_F00D, "R4 claimed write");
    cfg_read("R4 claimed read lat0");
    drain();
    check(last_key == 22'h000604, "R2 fields dev3 reg4", {10'b0, last_key}, 32'h000604);
    check(last_write == 1'b0, "R2 direction read", {31'b0, last_write}, 32'h0);

    // R4: latency 3, dev31 func1 reg3
    resp_lat = 3;
    set_addr(32'h8000_F90C);
    cfg_read("R4 lat3 default");
    cfg_write(32'h0BAD_C0DE, "R4 lat3 write");
    cfg_read("R4 lat3 readback");
    drain();
    check(last_key == 22'h003E43, "R2 fields dev31 func1", {10'b0, last_key}, 32'h003E43);

    // R2: extreme fields
    set_addr(32'h80FF_FFFF);
    cfg_write(32'h5A5A_A5A5, "R2 extreme write");
    cfg_read("R2 extreme readback");
    drain();
    check(last_key == 22'h3FFFFF, "R2 extreme fields", {10'b0, last_key}, 32'h3FFFFF);
    check(last_write == 1'b0, "R2 extreme direction", {31'b0, last_write}, 32'h0);

    // R5: nobody claims
    set_addr(32'h8000_4808);
    drain();
    t0 = txn_count;
    c0 = cyc;
    cfg_read("R5 abort read ones");
    drain();
    check(cyc - c0 >= TIMEOUT, "R5 waited for window", cyc - c0, TIMEOUT);
    cfg_write(32'h7777_7777, "R5 abort write");
    cfg_read("R5 abort read again");
    drain();
    check(txn_count == t0 + 3, "R5 requests issued", txn_count, t0 + 3);

    // R5: claim at the last accepted cycle
    resp_lat = TIMEOUT;
    set_addr(32'h8000_1810);
    cfg_read("R5 claim at window edge");
    drain();
    resp_lat = 1;

    // R6: stray addresses
    t0 = txn_count;
    io_access(1'b0, 16'h0CF4, 32'h0, ONES, 1'b1, "R6 stray read ones");
    io_access(1'b1, 16'h0080, 32'h0000_0001, 32'h0, 1'b0, "R6 stray write");
    io_access(1'b1, 16'h0D00, 32'h8012_3456, 32'h0, 1'b0, "R6 stray write near ports");
    io_access(1'b0, 16'hCF8, 32'h0, addr_model, 1'b1, "R6 address word unchanged");
    drain();
    check(txn_count == t0, "R6 no request", txn_count, t0);

    // R8: back-pressure on responses, back-to-back requests
    stall_mode = 1'b1;
    cfg_read("R8 stalled claimed read");
    io_access(1'b0, 16'hCF8, 32'h0, addr_model, 1'b1, "R8 stalled address read");
    set_addr(32'h8000_4808);
    cfg_read("R8 stalled abort read");
    drain();
    stall_mode = 1'b0;

    // R9: unsolicited claim is ignored, one request per access
    set_addr(32'h8000_F90C);
    drain();
    stray_req = 1'b1;
    repeat (2) @(negedge clk);
    check(io_rsp_valid === 1'b0, "R9 stray ack gives no response",
          {31'b0, io_rsp_valid}, 32'h0);
    t0 = txn_count;
    io_access(1'b0, 16'hCF8, 32'h0, addr_model, 1'b1, "R9 address after stray ack");
    cfg_read("R9 read after stray ack");
    drain();
    check(txn_count == t0 + 1, "R9 one request per access", txn_count, t0 + 1);

    finish_run();
  end

endmodule